// File: doc/BRIEF.md
# Pointer-Addressed SMBus Register Slave

This block is a two-wire bus target for a small set of configuration and status registers. It watches oversampled SCL and SDA lines on the system clock and pulls SDA low through an open-drain enable when it acknowledges or sends a zero. It answers one fixed 7-bit bus address. All register traffic goes through an 8-bit pointer. In a write transfer the first byte after the address always loads the pointer, and any later bytes go to the register the pointer selects. A read transfer returns the register at the current pointer. The pointer keeps its value between transfers, so a register can be polled repeatedly without writing the pointer again.

Two registers have split access. They are written through one pointer value and read back through another. Reading through the write-side value returns a fill byte instead of the register contents. The pointer never auto-increments. Extra bytes in one transfer keep hitting the same register.

Top module: `smb_ptr_slave`

## Requirements
- R1: The slave responds only to bus address 0x4C (0x4D when `ALT_ADDR`=1). The byte after START carries the 7-bit address MSB first, followed by R/W (0 = write, 1 = read). On a mismatch it does not acknowledge, leaves SDA released, ignores the rest of the transfer and changes no state.
- R2: START is SDA falling while SCL is high, and it also serves as a repeated start. STOP is SDA rising while SCL is high. STOP returns the slave to idle from any state. A write byte cut short by STOP or START changes no register.
- R3: After a matching address byte, and after every byte received in a write transfer, the slave drives SDA low for the ninth clock.
- R4: The first data byte of a write transfer is loaded into the pointer. No other event changes the pointer.
- R5: Each further byte in a write transfer is stored into the register the pointer selects. A write transfer that carries only the pointer byte changes no register.
- R6: A read transfer sends the register at the current pointer, MSB first. The pointer keeps its value across transfers.
- R7: Register map:
  - control register: written at pointer 0x09, read at pointer 0x03, reset value 0x00.
  - rate register: written at 0x0A, read at 0x04, reset value 0x08.
  - limit register: written and read at 0x05, reset value 0x55.
  - identity register: read-only at 0xFE, always 0x41.
- R8: A read at a write-only pointer value (0x09, 0x0A) or at an unmapped value returns 0xFF.
- R9: A write at a read-only pointer value (0x03, 0x04, 0xFE) or at an unmapped value is acknowledged and discarded.
- R10: The pointer does not auto-increment. Repeated read bytes return the same register, and repeated write bytes overwrite the same register.
- R11: A master no-acknowledge (SDA high on the ninth clock of a read byte) ends the read. The slave then keeps SDA released until the next START.
- R12: The R/W bit fixes the direction for the whole transfer. In a write transfer the slave drives SDA only in acknowledge slots. In a read transfer it never drives the master's acknowledge slot.
- R13: After reset SDA is released, the pointer is 0x00 and the registers hold their R7 reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| sda_oe | output | 1 | Drives SDA low when 1, releases it when 0 |

## Verification
The bench targets the split pointer pair.
- Reading through a write-only value must give 0xFF. A design that decoded one pointer for both directions would leak the control or rate register there.
- Polling after a single pointer write must return the same register byte after byte. An auto-incrementing or pointer-clearing design would return 0xFF or a neighbour instead.

It also covers transfer boundaries.
- A STOP in the middle of a data byte must leave the registers untouched, and a repeated start must switch direction without losing the pointer.
- An address miss must not disturb the pointer, and a NACK must release the line. A design that got these wrong would misdirect later reads or hold SDA low against the next START.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int          BYTE_W    = 8;
  localparam logic [6:0]  BASE_ADDR = 7'h4C;

  // pointer map: split pairs for control and rate, shared for limit
  localparam logic [7:0]  P_CTRL_RD  = 8'h03;
  localparam logic [7:0]  P_CTRL_WR  = 8'h09;
  localparam logic [7:0]  P_RATE_RD  = 8'h04;
  localparam logic [7:0]  P_RATE_WR  = 8'h0A;
  localparam logic [7:0]  P_LIMIT    = 8'h05;
  localparam logic [7:0]  P_IDENT_RD = 8'hFE;
  localparam logic [7:0]  IDENT_VAL  = 8'h41;
  localparam logic [7:0]  FILL_VAL   = 8'hFF;
  localparam int          NUM_WREG   = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WDATA, ST_WACK, ST_RDATA, ST_RACK
  } smb_state_e;

  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0, SEL_RATE = 3'd1, SEL_LIMIT = 3'd2,
    SEL_IDENT = 3'd3, SEL_NONE = 3'd4
  } reg_sel_e;

  function automatic logic [6:0] own_addr(input bit alt);
    return BASE_ADDR | {6'd0, alt};
  endfunction

  function automatic reg_sel_e wr_target(input logic [7:0] p);
    case (p)
      P_CTRL_WR: return SEL_CTRL;
      P_RATE_WR: return SEL_RATE;
      P_LIMIT:   return SEL_LIMIT;
      default:   return SEL_NONE;
    endcase
  endfunction

  function automatic reg_sel_e rd_target(input logic [7:0] p);
    case (p)
      P_CTRL_RD:  return SEL_CTRL;
      P_RATE_RD:  return SEL_RATE;
      P_LIMIT:    return SEL_LIMIT;
      P_IDENT_RD: return SEL_IDENT;
      default:    return SEL_NONE;
    endcase
  endfunction

  function automatic logic [7:0] reset_value(input int idx);
    case (idx)
      0:       return 8'h00;
      1:       return 8'h08;
      default: return 8'h55;
    endcase
  endfunction
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_rise,
  output logic sda_fall
);
  // each stage holds {scl, sda}; bus idles high
  logic [STAGES-1:0][1:0] chain;
  logic [1:0]             prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 2'b11;
    end else begin
      chain <= {chain[STAGES-2:0], {scl_i, sda_i}};
      prev  <= chain[STAGES-1];
    end
  end

  assign scl_s    = chain[STAGES-1][1];
  assign sda_s    = chain[STAGES-1][0];
  assign scl_rise =  scl_s & ~prev[1];
  assign scl_fall = ~scl_s &  prev[1];
  assign sda_rise =  sda_s & ~prev[0];
  assign sda_fall = ~sda_s &  prev[0];
endmodule

// File: rtl/smb_regfile.sv
module smb_regfile
  import smb_pkg::*;
#(
  parameter int NREG = NUM_WREG
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_ptr,
  input  logic [7:0] wr_data,
  input  logic [7:0] rd_ptr,
  output logic [7:0] rd_data
);
  reg_sel_e              wsel;
  reg_sel_e              rsel;
  logic                  wr_hit;
  logic [NREG-1:0][7:0]  store;

  assign wsel   = wr_target(wr_ptr);
  assign rsel   = rd_target(rd_ptr);
  assign wr_hit = (wsel != SEL_NONE);

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   q <= reset_value(g);
        else if (wr_en && wsel == reg_sel_e'(3'(g)))  q <= wr_data;
      end
      assign store[g] = q;
    end
  endgenerate

  always_comb begin
    case (rsel)
      SEL_CTRL:  rd_data = store[0];
      SEL_RATE:  rd_data = store[1];
      SEL_LIMIT: rd_data = store[2];
      SEL_IDENT: rd_data = IDENT_VAL;
      default:   rd_data = FILL_VAL;
    endcase
  end

  // R9: a write aimed at no writable register leaves every register intact
  a_r9_discard_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hit) |=> $stable(store));
  // R5: without a write strobe no register moves
  a_r5_hold_unwritten: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> $stable(store));
endmodule

// File: rtl/smb_ptr_slave.sv
module smb_ptr_slave
  import smb_pkg::*;
#(
  parameter bit ALT_ADDR    = 1'b0,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam logic [6:0] MY_ADDR = own_addr(ALT_ADDR);
  localparam int         CNT_W   = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  logic scl_s, sda_s, scl_rise, scl_fall, sda_rise, sda_fall;
  logic start_evt, stop_evt, byte_done, addr_hit, ptr_load, reg_wr;

  smb_state_e       state;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       shreg, txreg, ptr, rd_data;
  logic             rw, first_byte, mnack, oe_q;

  smb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_rise(sda_rise), .sda_fall(sda_fall)
  );

  // bus events, named for the checks below
  assign start_evt = sda_fall & scl_s;
  assign stop_evt  = sda_rise & scl_s;
  assign byte_done = scl_fall & (cnt == CNT_FULL);
  assign addr_hit  = (shreg[7:1] == MY_ADDR);
  assign ptr_load  = (state == ST_WDATA) & byte_done &  first_byte & ~start_evt & ~stop_evt;
  assign reg_wr    = (state == ST_WDATA) & byte_done & ~first_byte & ~start_evt & ~stop_evt;

  smb_regfile #(.NREG(NUM_WREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_ptr(ptr), .wr_data(shreg),
    .rd_ptr(ptr), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr <= 8'h00;
    else if (ptr_load) ptr <= shreg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      shreg      <= '0;
      txreg      <= '0;
      rw         <= 1'b0;
      first_byte <= 1'b0;
      mnack      <= 1'b0;
      oe_q       <= 1'b0;
    end else if (stop_evt) begin
      state <= ST_IDLE;
      oe_q  <= 1'b0;
    end else if (start_evt) begin
      state <= ST_ADDR;
      cnt   <= '0;
      oe_q  <= 1'b0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (scl_rise) begin
            shreg <= {shreg[6:0], sda_s};
            cnt   <= cnt + 1'b1;
          end else if (byte_done) begin
            if (addr_hit) begin
              state <= ST_ADDR_ACK;
              oe_q  <= 1'b1;
              rw    <= shreg[0];
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              txreg <= rd_data;
              oe_q  <= ~rd_data[7];
              state <= ST_RDATA;
            end else begin
              oe_q       <= 1'b0;
              first_byte <= 1'b1;
              state      <= ST_WDATA;
            end
          end
        end
        ST_WDATA: begin
          if (scl_rise) begin
            shreg <= {shreg[6:0], sda_s};
            cnt   <= cnt + 1'b1;
          end else if (byte_done) begin
            oe_q       <= 1'b1;
            first_byte <= 1'b0;
            state      <= ST_WACK;
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            oe_q  <= 1'b0;
            cnt   <= '0;
            state <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            cnt <= cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == CNT_FULL) begin
              oe_q  <= 1'b0;
              state <= ST_RACK;
            end else begin
              txreg <= {txreg[6:0], 1'b0};
              oe_q  <= ~txreg[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mnack <= sda_s;
          end else if (scl_fall) begin
            if (mnack) begin
              state <= ST_IDLE;
            end else begin
              txreg <= rd_data;
              oe_q  <= ~rd_data[7];
              cnt   <= '0;
              state <= ST_RDATA;
            end
          end
        end
        default: oe_q <= 1'b0;
      endcase
    end
  end

  assign sda_oe = oe_q;

  // R2: STOP always lands in idle with the line released
  a_r2_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (state == ST_IDLE && !sda_oe));
  // R1: an address miss leaves the bus alone
  a_r1_miss_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR && byte_done && !addr_hit && !start_evt && !stop_evt)
      |=> (state == ST_IDLE && !sda_oe));
  // R3: the line is held low for the whole acknowledge slot
  a_r3_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ADDR_ACK || state == ST_WACK) |-> sda_oe);
  // R4: only the first write byte moves the pointer
  a_r4_ptr_only_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_load) |=> $stable(ptr));
  // R11: a master NACK ends the read and frees the line
  a_r11_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RACK && scl_fall && mnack && !start_evt && !stop_evt)
      |=> (state == ST_IDLE && !sda_oe));
  // R12: the master owns SDA during write data bits and the master ack slot
  a_r12_master_slots: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WDATA || state == ST_RACK) |-> !sda_oe);
  // R13: idle never drives the line
  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);
endmodule

// File: tb/smb_ptr_slave_tb.sv
`timescale 1ns/1ps
module smb_ptr_slave_tb;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  int   checks = 0;
  int   failures = 0;
  bit   quiet = 1'b0;
  bit   done = 1'b0;

  // behavioural register model
  logic [7:0] m_ctrl = 8'h00, m_rate = 8'h08, m_limit = 8'h55, m_ptr = 8'h00;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  smb_ptr_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  function automatic logic [7:0] exp_rd(input logic [7:0] p);
    if (p == 8'h03) return m_ctrl;
    if (p == 8'h04) return m_rate;
    if (p == 8'h05) return m_limit;
    if (p == 8'hFE) return 8'h41;
    return 8'hFF;
  endfunction

  task automatic m_write(input logic [7:0] p, input logic [7:0] d);
    if (p == 8'h09) m_ctrl = d;
    else if (p == 8'h0A) m_rate = d;
    else if (p == 8'h05) m_limit = d;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison: in master-owned windows the slave must not drive
  always @(negedge clk) begin
    if (rst_n && quiet) begin
      checks++;
      if (sda_oe) begin
        failures++;
        $display("FAIL R12 slave drove SDA in a master slot actual=1 expected=0");
      end
    end
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic do_start();
    if (scl_m) begin
      sda_m = 1'b0; wq(); scl_m = 1'b0;
    end else begin
      wq(); quiet = 1'b1; sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
      sda_m = 1'b0; wq(); scl_m = 1'b0;
    end
  endtask

  task automatic do_stop();
    wq(); quiet = 1'b1; sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic put_bit(input bit b);
    wq(); quiet = 1'b1; sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    quiet = 1'b0;
    wq(); sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    acked = (sda_line == 1'b0);
    wq(); scl_m = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit nack);
    logic ackv;
    quiet = 1'b0;
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      wq(); sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
      b = {b[6:0], sda_line};
      wq(); scl_m = 1'b0;
    end
    wq(); if (nack) quiet = 1'b1; sda_m = nack; wq(); scl_m = 1'b1; wq();
    ackv = sda_line;
    wq(); scl_m = 1'b0;
    chk("R12 master ack slot not driven by slave", ackv, nack);
  endtask

  task automatic wr_xfer(input logic [6:0] a, input logic [7:0] data[$], input string tag);
    bit ack;
    bit hit = (a == 7'h4C);
    do_start();
    send_byte({a, 1'b0}, ack);
    chk({"R1 address ack ", tag}, ack, hit);
    foreach (data[i]) begin
      send_byte(data[i], ack);
      chk({"R3 write byte ack ", tag}, ack, hit);
      if (hit) begin
        if (i == 0) m_ptr = data[i];
        else m_write(m_ptr, data[i]);
      end
    end
    do_stop();
  endtask

  task automatic rd_xfer(input int n, input string tag);
    bit ack;
    logic [7:0] b;
    do_start();
    send_byte({7'h4C, 1'b1}, ack);
    chk({"R1 read address ack ", tag}, ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(b, i == n - 1);
      chk(tag, b, exp_rd(m_ptr));
    end
    do_stop();
    chk("R11 line released after NACK", sda_oe, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] b;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    quiet = 1'b1;
    chk("R13 SDA released after reset", sda_oe, 0);
    wq();
    rd_xfer(1, "R13 reset pointer 0x00 reads fill R8");
    rd_xfer(1, "R13 unmapped pointer still fill");
    // pointer then data, then poll without a pointer write
    wr_xfer(7'h4C, {8'h05, 8'hA3}, "R4 R5 limit write");
    rd_xfer(3, "R6 R10 limit polled without pointer write");
    // split control register
    wr_xfer(7'h4C, {8'h09, 8'h3C}, "R7 control via write pointer");
    rd_xfer(1, "R8 write-only pointer reads fill");
    wr_xfer(7'h4C, {8'h03}, "R5 pointer-only write");
    rd_xfer(2, "R7 control via read pointer");
    // wrong address: no ack, nothing changes
    wr_xfer(7'h4D, {8'h05, 8'h00}, "R1 miss 0x4D");
    wr_xfer(7'h4E, {8'h0A, 8'h99}, "R1 miss 0x4E");
    rd_xfer(1, "R1 pointer untouched by miss");
    // read-only target, unmapped target
    wr_xfer(7'h4C, {8'hFE, 8'h00}, "R9 write to identity");
    rd_xfer(1, "R9 R7 identity unchanged");
    wr_xfer(7'h4C, {8'h0B, 8'h77}, "R9 write to unmapped");
    rd_xfer(1, "R8 unmapped read fill");
    // repeated writes overwrite one register
    wr_xfer(7'h4C, {8'h0A, 8'h11, 8'h22}, "R10 rate double write");
    wr_xfer(7'h4C, {8'h04}, "R4 rate read pointer");
    rd_xfer(1, "R10 R7 rate holds last byte");
    wr_xfer(7'h4C, {8'h03}, "R9 pointer to read-only control");
    wr_xfer(7'h4C, {8'h03, 8'hEE}, "R9 write through read pointer");
    rd_xfer(1, "R9 control unchanged");
    // STOP in the middle of a data byte
    do_start();
    send_byte({7'h4C, 1'b0}, ack);
    chk("R1 ack before abort", ack, 1);
    send_byte(8'h05, ack);
    chk("R3 pointer ack before abort", ack, 1);
    m_ptr = 8'h05;
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    do_stop();
    rd_xfer(1, "R2 limit unchanged after mid-byte STOP");
    // repeated start: write pointer then read in one bus ownership
    do_start();
    send_byte({7'h4C, 1'b0}, ack);
    chk("R1 ack before restart", ack, 1);
    send_byte(8'h03, ack);
    chk("R3 pointer ack before restart", ack, 1);
    m_ptr = 8'h03;
    do_start();
    send_byte({7'h4C, 1'b1}, ack);
    chk("R2 ack after repeated START", ack, 1);
    recv_byte(b, 1'b1);
    chk("R2 R6 read after repeated START", b, exp_rd(m_ptr));
    do_stop();
    // idle period after NACK stays quiet (monitored every clock)
    repeat (20) wq();
    chk("R11 still released in idle", sda_oe, 0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule